// File: doc/BRIEF.md
# Windowed-Refresh Software Watchdog

This block is a watchdog under software control, built around a 16-bit up-counter. A prescaler turns the input clock into a counting tick. Bit 7 of an 8-bit reload register picks the tick period. With the default parameters the period is either 24 or 384 clock cycles. After reset the watchdog is idle. The first start strobe sets it running, and from then on nothing but reset can stop it.

To keep the watchdog from firing, the host performs a two-step refresh. It first pulses the arm strobe. It then pulses the start strobe within a twelve-cycle window. A refresh loads the counter from the low seven bits of the reload register and restarts the prescaler. If the counter climbs to the fixed terminal value 0x7CFF, the timeout output rises and a one-cycle reset request pulse is issued. A sticky status flag is also set and holds until reset. The counter and prescaler are visible on parallel outputs.

Top module: `wdt_soft_watchdog`

## Requirements
- R1: After reset the counter, prescaler, timeout, reset request and status flag are all zero, and the counter does not advance until a start strobe arrives.
- R2: Once running, the counter increases by one every FAST_DIV cycles when reload bit 7 is 0, and every FAST_DIV*SLOW_MULT cycles when it is 1. The defaults give 24 and 384. Counting begins on the edge after the one that samples the enabling start strobe.
- R3: Once started, the watchdog keeps counting. Later start strobes, arm strobes and reload-register writes never stop it; only reset does.
- R4: timeoutOut is high exactly while the counter holds 0x7CFF, and it drops as soon as the counter moves on.
- R5: resetReqOut is a single-cycle pulse, high only in the first cycle the counter holds 0x7CFF.
- R6: statusFlag rises together with the timeout and stays high until reset.
- R7: A start strobe sampled 1 to ARM_WINDOW edges after an arm strobe loads the counter with {0, reload[6:0], 8'h00}. ARM_WINDOW defaults to 12.
- R8: A start strobe sampled more than ARM_WINDOW edges after the arm strobe causes no reload. The same holds for a start strobe with no preceding arm.
- R9: A reload clears the prescaler, so the first increment after a refresh comes one full tick period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armStb | input | 1 | First step of the refresh sequence |
| startStb | input | 1 | Starts the watchdog; completes a refresh while armed |
| relWrEn | input | 1 | Write enable for the reload register |
| relWrData | input | 8 | Reload register data (bit 7 = slow tick) |
| cntOut | output | 16 | Counter value |
| preOut | output | $clog2(FAST_DIV*SLOW_MULT) | Prescaler value |
| timeoutOut | output | 1 | High while counter equals 0x7CFF |
| resetReqOut | output | 1 | One-cycle reset request |
| statusFlag | output | 1 | Sticky timeout status |

## Verification
The bench builds the block with FAST_DIV=4 and SLOW_MULT=4, which gives tick periods of 4 and 16 cycles. The window and the terminal value keep their defaults. The short ticks make it cheap to check the counter and prescaler on every cycle of long runs in both speeds. They also make it possible to sweep every arm-to-start spacing from 1 to 14. A refresh to 0x7C00 reaches the terminal value in about a thousand cycles, so the timeout, request pulse and sticky flag are all observed around that point.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic run;     // watchdog counting enabled
    logic reload;  // load counter from reload image this edge
  } wdtCtl_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ARM_WINDOW = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    armStb,
  input  logic    startStb,
  output wdtCtl_t ctl
);
  localparam int AGE_W = $clog2(ARM_WINDOW + 1);

  logic             enabledQ;
  logic             armedQ;
  logic [AGE_W-1:0] ageQ;
  logic             reloadHit;

  assign reloadHit = startStb & armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabledQ <= 1'b0;
      armedQ   <= 1'b0;
      ageQ     <= '0;
    end else begin
      if (startStb) enabledQ <= 1'b1;
      if (reloadHit) begin
        armedQ <= 1'b0;
        ageQ   <= '0;
      end else if (armStb) begin
        armedQ <= 1'b1;
        ageQ   <= '0;
      end else if (armedQ) begin
        if (ageQ == AGE_W'(ARM_WINDOW - 1)) begin
          armedQ <= 1'b0;
          ageQ   <= '0;
        end else begin
          ageQ <= ageQ + 1'b1;
        end
      end
    end
  end

  assign ctl.run    = enabledQ;
  assign ctl.reload = reloadHit;

  // R3: enable is never withdrawn outside reset
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enabledQ |=> enabledQ);
  // R8: the arm window never outlives its length
  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (ageQ < AGE_W'(ARM_WINDOW)));
  // R8: an unanswered arm expires at the last window edge
  a_r8_arm_expires: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && ageQ == AGE_W'(ARM_WINDOW - 1) && !startStb && !armStb) |=> !armedQ);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          RLD_W     = 8,
  parameter logic [15:0] TERMINAL  = 16'h7CFF,
  parameter int          FAST_DIV  = 24,
  parameter int          SLOW_MULT = 16,
  localparam int         SLOW_DIV  = FAST_DIV * SLOW_MULT,
  localparam int         PRE_W     = $clog2(SLOW_DIV)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtCtl_t          ctl,
  input  logic             relWrEn,
  input  logic [RLD_W-1:0] relWrData,
  output logic [CNT_W-1:0] cntOut,
  output logic [PRE_W-1:0] preOut,
  output logic             timeoutOut,
  output logic             resetReqOut,
  output logic             statusFlag
);
  localparam int LOW_W = CNT_W - RLD_W;

  logic [RLD_W-1:0] reloadQ;
  logic [CNT_W-1:0] cntQ, cntD, reloadImage;
  logic [PRE_W-1:0] preQ, preD, preLast;
  logic             reqQ, flagQ, hitD, atTerm;

  assign reloadImage = CNT_W'(reloadQ[RLD_W-2:0]) << LOW_W;
  assign preLast     = reloadQ[RLD_W-1] ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
  assign atTerm      = (cntQ == CNT_W'(TERMINAL));

  always_comb begin
    cntD = cntQ;
    preD = preQ;
    if (ctl.reload) begin
      cntD = reloadImage;
      preD = '0;
    end else if (ctl.run) begin
      if (preQ >= preLast) begin
        preD = '0;
        cntD = cntQ + 1'b1;
      end else begin
        preD = preQ + 1'b1;
      end
    end
  end

  assign hitD = (cntD == CNT_W'(TERMINAL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      cntQ    <= '0;
      preQ    <= '0;
      reqQ    <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (relWrEn) reloadQ <= relWrData;
      cntQ  <= cntD;
      preQ  <= preD;
      reqQ  <= hitD && !atTerm;
      flagQ <= flagQ | hitD;
    end
  end

  assign cntOut      = cntQ;
  assign preOut      = preQ;
  assign timeoutOut  = atTerm;
  assign resetReqOut = reqQ;
  assign statusFlag  = flagQ;

  // R2: a running counter moves by at most one per edge
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.reload) |=> (cntQ == $past(cntQ) || cntQ == $past(cntQ) + 1'b1));
  // R4: timeout never appears without the status flag
  a_r4_timeout_flag: assert property (@(posedge clk) disable iff (!rstN)
    timeoutOut |-> statusFlag);
  // R5: request only on the first terminal cycle, and only for one cycle
  a_r5_req_first: assert property (@(posedge clk) disable iff (!rstN)
    resetReqOut |-> (timeoutOut && $past(cntQ) != CNT_W'(TERMINAL)));
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rstN)
    resetReqOut |=> !resetReqOut);
  // R6: flag holds until reset
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusFlag |=> statusFlag);
  // R7 / R9: reload lands the image and clears the prescaler
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reload |=> (cntQ == $past(reloadImage) && preQ == '0));
endmodule

// File: rtl/wdt_soft_watchdog.sv
module wdt_soft_watchdog
  import wdt_pkg::*;
#(
  parameter int          FAST_DIV   = 24,
  parameter int          SLOW_MULT  = 16,
  parameter int          ARM_WINDOW = 12,
  parameter logic [15:0] TERMINAL   = 16'h7CFF,
  localparam int         PRE_W      = $clog2(FAST_DIV * SLOW_MULT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armStb,
  input  logic             startStb,
  input  logic             relWrEn,
  input  logic [7:0]       relWrData,
  output logic [15:0]      cntOut,
  output logic [PRE_W-1:0] preOut,
  output logic             timeoutOut,
  output logic             resetReqOut,
  output logic             statusFlag
);
  wdtCtl_t ctl;

  wdt_ctrl #(.ARM_WINDOW(ARM_WINDOW)) uCtrl (
    .clk(clk), .rstN(rstN), .armStb(armStb), .startStb(startStb), .ctl(ctl)
  );

  wdt_datapath #(
    .CNT_W(16), .RLD_W(8), .TERMINAL(TERMINAL),
    .FAST_DIV(FAST_DIV), .SLOW_MULT(SLOW_MULT)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .relWrEn(relWrEn), .relWrData(relWrData),
    .cntOut(cntOut), .preOut(preOut),
    .timeoutOut(timeoutOut), .resetReqOut(resetReqOut), .statusFlag(statusFlag)
  );
endmodule

// File: tb/sim_wdt_soft_watchdog.sv
`timescale 1ns/1ps
module sim_wdt_soft_watchdog;
  localparam int FD = 4;
  localparam int SM = 4;
  localparam int PW = $clog2(FD * SM);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armStb = 1'b0, startStb = 1'b0, relWrEn = 1'b0;
  logic [7:0] relWrData = '0;
  logic [15:0] cntOut;
  logic [PW-1:0] preOut;
  logic timeoutOut, resetReqOut, statusFlag;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_soft_watchdog #(.FAST_DIV(FD), .SLOW_MULT(SM)) u0 (
    .clk(clk), .rstN(rstN), .armStb(armStb), .startStb(startStb),
    .relWrEn(relWrEn), .relWrData(relWrData), .cntOut(cntOut), .preOut(preOut),
    .timeoutOut(timeoutOut), .resetReqOut(resetReqOut), .statusFlag(statusFlag)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; armStb = 0; startStb = 0; relWrEn = 0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic writeRel(logic [7:0] v);
    relWrData = v; relWrEn = 1'b1; step(); relWrEn = 1'b0;
  endtask

  task automatic pulseStart(); startStb = 1'b1; step(); startStb = 1'b0; endtask
  task automatic pulseArm();   armStb = 1'b1;   step(); armStb = 1'b0;   endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle without start
    doReset();
    chk("R1 cnt", cntOut, 0); chk("R1 pre", preOut, 0);
    chk("R1 to", timeoutOut, 0); chk("R1 req", resetReqOut, 0); chk("R1 flag", statusFlag, 0);
    repeat (10) step();
    chk("R1 idle cnt", cntOut, 0); chk("R1 idle pre", preOut, 0);

    // R2: fast tick sweep, every cycle
    pulseStart();
    for (int m = 1; m <= 48; m++) begin
      step();
      chk("R2 fast cnt", cntOut, m / FD); chk("R2 fast pre", preOut, m % FD);
    end

    // R2: slow tick sweep
    doReset();
    writeRel(8'h80);
    pulseStart();
    for (int m = 1; m <= 80; m++) begin
      step();
      chk("R2 slow cnt", cntOut, m / (FD * SM)); chk("R2 slow pre", preOut, m % (FD * SM));
    end

    // R7 / R8 / R9: sweep arm-to-start spacing
    for (int k = 1; k <= 14; k++) begin
      doReset();
      writeRel(8'h05);
      pulseStart();            // enabling edge, m = 0
      repeat (3) step();       // m = 3
      pulseArm();              // m = 4
      repeat (k - 1) step();
      pulseStart();            // m = 4 + k
      if (k <= 12) begin
        chk("R7 reload cnt", cntOut, 16'h0500); chk("R9 reload pre", preOut, 0);
        repeat (FD - 1) step();
        chk("R9 no early tick", cntOut, 16'h0500);
        step();
        chk("R9 first tick", cntOut, 16'h0501);
      end else begin
        chk("R8 late start cnt", cntOut, (4 + k) / FD);
        chk("R8 late start pre", preOut, (4 + k) % FD);
      end
    end

    // R4 / R5 / R6: reach terminal value
    doReset();
    writeRel(8'h7C);
    pulseArm();
    pulseStart();
    chk("R7 image", cntOut, 16'h7C00);
    repeat (255 * FD - 1) step();
    chk("R4 before", cntOut, 16'h7CFE); chk("R4 to low", timeoutOut, 0);
    chk("R5 req low", resetReqOut, 0); chk("R6 flag low", statusFlag, 0);
    step();
    chk("R4 at term", cntOut, 16'h7CFF); chk("R4 to high", timeoutOut, 1);
    chk("R5 req pulse", resetReqOut, 1); chk("R6 flag set", statusFlag, 1);
    step();
    chk("R5 req single", resetReqOut, 0); chk("R4 to held", timeoutOut, 1);
    repeat (FD - 1) step();
    chk("R4 moved", cntOut, 16'h7D00); chk("R4 to clear", timeoutOut, 0);
    chk("R6 flag sticky", statusFlag, 1);

    // R3 / R8: unarmed start and reload write neither stop nor reload
    writeRel(8'h00);   // m = 1 past 0x7D00
    pulseStart();      // m = 2
    chk("R8 no reload", cntOut, 16'h7D00); chk("R3 pre", preOut, 2);
    repeat (2) step();
    chk("R3 still counting", cntOut, 16'h7D01);
    chk("R6 flag still", statusFlag, 1);
    doReset();
    chk("R6 flag reset", statusFlag, 0); chk("R1 cnt after", cntOut, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule